// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 34-bit physical address. It reads a two-level page table from memory, one 32-bit word at a time, through a request/response port. A caller presents the address, the kind of access (load, store or instruction fetch), a translation-enable bit and the page number of the root table. One cycle-wide completion pulse later carries the outcome. On success the outcome is the physical address, the low ten bits of the final table entry and whether the page is 4 KB or 4 MB. On failure it is a page-fault cause code that the trap logic can use as it stands.

Only one translation is in flight at a time. The walker keeps a busy flag raised while it waits on memory, and memory may stall both the request and the response for any number of cycles. Translation uses 4 KB pages and 4 MB pages, where a first-level entry is itself the leaf. Each entry is checked for validity, for reserved encodings, for alignment and for the permission the access kind needs.

Top module: `xlat_walker`

## Requirements
- R1: After reset `busy`, `done` and `mem_req_valid` are low.
- R2: A request accepted with `xlat_on` low completes on the next cycle with no memory read and no fault, and `done_paddr` equals `req_vaddr` zero-extended to 34 bits.
- R3: With `xlat_on` high, the first read goes to `{root_ppn, VA[31:22], 2'b00}`, using the `root_ppn` value sampled when the request was accepted.
- R4: A first-level entry with V (bit 0) set and R, W, X (bits 1, 2, 3) all clear points to the next table. The second read goes to `{PTE[31:10], VA[21:12], 2'b00}`.
- R5: A valid second-level leaf gives `done_paddr = {PTE[31:10], VA[11:0]}`, `done_attr = PTE[9:0]` and `done_mega = 0`.
- R6: A first-level entry with any of R/W/X set is a 4 MB leaf. It gives `done_paddr = {PTE[31:20], VA[21:0]}` and `done_mega = 1`, and the walk makes no second read.
- R7: An entry with V clear, at either level, ends the walk with a fault.
- R8: A valid second-level entry with R, W and X all clear faults.
- R9: Access kind codes on `req_kind` are 0 load, 1 store, 2 fetch, and 3 is handled as a load. A leaf faults when the kind's permission bit is clear: R for load, W for store, X for fetch.
- R10: An entry with W set and R clear faults at either level, even for a store.
- R11: A 4 MB leaf whose PTE[19:10] is nonzero faults.
- R12: A fault sets `done_fault` and gives cause 12 for fetch, 13 for load and 15 for store. `done_paddr`, `done_attr` and `done_mega` are then zero. A success gives cause 0.
- R13: `busy` is high from the cycle after acceptance until the `done` cycle, and `done` lasts one cycle. `req_valid` has no effect while `busy` is high. `mem_req_valid` is only high while busy, and its address holds steady until `mem_req_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request, taken when `busy` is low |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| xlat_on | input | 1 | Translation enable; low passes the address through |
| root_ppn | input | 22 | Page number of the root table |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Word read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 34 | Byte address of the word to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Read data (a table entry) |
| done | output | 1 | One-cycle completion pulse |
| done_fault | output | 1 | The translation faulted |
| done_cause | output | 4 | Fault cause code (12, 13 or 15), 0 on success |
| done_paddr | output | 34 | Physical address |
| done_attr | output | 10 | Low ten bits of the leaf entry |
| done_mega | output | 1 | The leaf is a 4 MB page |

## Verification
The bench targets the entry classes that a walker most easily confuses. A walker that did not split pointers from leaves by R/W/X would make a second read from the 4 MB leaf, or accept a non-leaf second-level entry as a page. A walker that dropped the alignment test, or the W-without-R test, would return an address where a fault is due. A walker that picked the wrong permission bit for the access kind, or swapped the cause codes, would report a load fault as a store fault. Memory stalls vary from walk to walk. A stray request is pulsed in the middle of a walk, where a walker that re-sampled its inputs would produce a second, spurious completion.

// File: rtl/xw_pkg.sv
package xw_pkg;

    localparam int VA_W      = 32;
    localparam int PTE_W     = 32;
    localparam int OFF_W     = 12;
    localparam int VPN_W     = 10;
    localparam int PPN_W     = 22;
    localparam int PA_W      = PPN_W + OFF_W;
    localparam int ATTR_W    = 10;
    localparam int CAUSE_W   = 4;
    localparam int LEVELS    = 2;
    localparam int MEGA_HI_W = PPN_W - VPN_W;
    localparam int ZEXT_W    = PA_W - VA_W;

    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam logic [CAUSE_W-1:0] CAUSE_FETCH = 4'd12;
    localparam logic [CAUSE_W-1:0] CAUSE_LOAD  = 4'd13;
    localparam logic [CAUSE_W-1:0] CAUSE_STORE = 4'd15;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RD1  = 3'd1,
        ST_WT1  = 3'd2,
        ST_RD0  = 3'd3,
        ST_WT0  = 3'd4
    } walk_st_e;

    typedef struct packed {
        walk_st_e            st;
        logic [VA_W-1:0]     va;
        logic [1:0]          kind;
        logic [PPN_W-1:0]    root;
        logic [PPN_W-1:0]    next_ppn;
        logic                done;
        logic                fault;
        logic [CAUSE_W-1:0]  cause;
        logic [PA_W-1:0]     pa;
        logic [ATTR_W-1:0]   attr;
        logic                mega;
    } walk_t;

    function automatic logic [CAUSE_W-1:0] fault_cause(input logic [1:0] kind);
        case (kind)
            ACC_STORE: return CAUSE_STORE;
            ACC_FETCH: return CAUSE_FETCH;
            default:   return CAUSE_LOAD;
        endcase
    endfunction

endpackage

// File: rtl/xw_pte_check.sv
module xw_pte_check
    import xw_pkg::*;
#(
    parameter bit IS_TOP = 1'b0
) (
    input  logic [3:0]       perm,
    input  logic [VPN_W-1:0] ppn_lo,
    input  logic [1:0]       kind,
    output logic             is_ptr,
    output logic             fault
);

    logic v_bit, r_bit, w_bit, x_bit;
    logic leaf, reserved, misalign, perm_ok;

    always_comb begin
        v_bit    = perm[0];
        r_bit    = perm[1];
        w_bit    = perm[2];
        x_bit    = perm[3];
        leaf     = r_bit | w_bit | x_bit;
        reserved = w_bit & ~r_bit;
        misalign = IS_TOP && leaf && (ppn_lo != '0);
        case (kind)
            ACC_STORE: perm_ok = w_bit;
            ACC_FETCH: perm_ok = x_bit;
            default:   perm_ok = r_bit;
        endcase
        is_ptr = IS_TOP && v_bit && !leaf;
        fault  = !v_bit || reserved
               || (!leaf && !IS_TOP)
               || (leaf && (!perm_ok || misalign));
    end

endmodule

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
    import xw_pkg::*;
(
    input  logic [PPN_W-1:0] root_ppn,
    input  logic [VA_W-1:0]  va,
    input  logic [PPN_W-1:0] next_ppn,
    input  logic [PPN_W-1:0] leaf_ppn,
    output logic [PA_W-1:0]  l1_addr,
    output logic [PA_W-1:0]  l0_addr,
    output logic [PA_W-1:0]  pa_page,
    output logic [PA_W-1:0]  pa_mega
);

    localparam int IDX_SH = 2;

    logic [VPN_W-1:0] vpn_hi, vpn_lo;
    logic [OFF_W-1:0] offset;

    always_comb begin
        vpn_hi  = va[VA_W-1 -: VPN_W];
        vpn_lo  = va[OFF_W +: VPN_W];
        offset  = va[OFF_W-1:0];
        l1_addr = {root_ppn, vpn_hi, {IDX_SH{1'b0}}};
        l0_addr = {next_ppn, vpn_lo, {IDX_SH{1'b0}}};
        pa_page = {leaf_ppn, offset};
        pa_mega = {leaf_ppn[PPN_W-1 -: MEGA_HI_W], vpn_lo, offset};
    end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
    import xw_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [31:0]         req_vaddr,
    input  logic [1:0]          req_kind,
    input  logic                xlat_on,
    input  logic [21:0]         root_ppn,
    output logic                busy,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [33:0]         mem_req_addr,
    input  logic                mem_rsp_valid,
    input  logic [31:0]         mem_rsp_data,
    output logic                done,
    output logic                done_fault,
    output logic [3:0]          done_cause,
    output logic [33:0]         done_paddr,
    output logic [9:0]          done_attr,
    output logic                done_mega
);

    walk_t q, d;

    logic [LEVELS-1:0] lvl_ptr, lvl_fault;
    logic [PA_W-1:0]   l1_addr, l0_addr, pa_page, pa_mega;
    logic [PPN_W-1:0]  rsp_ppn;

    assign rsp_ppn = mem_rsp_data[PTE_W-1 -: PPN_W];

    // One entry checker per table level; the top level allows leaves.
    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
        xw_pte_check #(.IS_TOP(lv == LEVELS-1)) u_chk (
            .perm   (mem_rsp_data[3:0]),
            .ppn_lo (mem_rsp_data[ATTR_W +: VPN_W]),
            .kind   (q.kind),
            .is_ptr (lvl_ptr[lv]),
            .fault  (lvl_fault[lv])
        );
    end

    xw_addr_gen u_addr (
        .root_ppn (q.root),
        .va       (q.va),
        .next_ppn (q.next_ppn),
        .leaf_ppn (rsp_ppn),
        .l1_addr  (l1_addr),
        .l0_addr  (l0_addr),
        .pa_page  (pa_page),
        .pa_mega  (pa_mega)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.va   = req_vaddr;
                    d.kind = req_kind;
                    d.root = root_ppn;
                    if (xlat_on) begin
                        d.st = ST_RD1;
                    end else begin
                        d.done  = 1'b1;
                        d.fault = 1'b0;
                        d.cause = '0;
                        d.pa    = {{ZEXT_W{1'b0}}, req_vaddr};
                        d.attr  = '0;
                        d.mega  = 1'b0;
                    end
                end
            end
            ST_RD1: if (mem_req_ready) d.st = ST_WT1;
            ST_WT1: begin
                if (mem_rsp_valid) begin
                    if (lvl_fault[LEVELS-1]) begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.fault = 1'b1;
                        d.cause = fault_cause(q.kind);
                        d.pa    = '0;
                        d.attr  = '0;
                        d.mega  = 1'b0;
                    end else if (lvl_ptr[LEVELS-1]) begin
                        d.next_ppn = rsp_ppn;
                        d.st       = ST_RD0;
                    end else begin
                        d.st    = ST_IDLE;
                        d.done  = 1'b1;
                        d.fault = 1'b0;
                        d.cause = '0;
                        d.pa    = pa_mega;
                        d.attr  = mem_rsp_data[ATTR_W-1:0];
                        d.mega  = 1'b1;
                    end
                end
            end
            ST_RD0: if (mem_req_ready) d.st = ST_WT0;
            ST_WT0: begin
                if (mem_rsp_valid) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                    d.mega = 1'b0;
                    if (lvl_fault[0]) begin
                        d.fault = 1'b1;
                        d.cause = fault_cause(q.kind);
                        d.pa    = '0;
                        d.attr  = '0;
                    end else begin
                        d.fault = 1'b0;
                        d.cause = '0;
                        d.pa    = pa_page;
                        d.attr  = mem_rsp_data[ATTR_W-1:0];
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy          = (q.st != ST_IDLE);
    assign mem_req_valid = (q.st == ST_RD1) || (q.st == ST_RD0);
    assign mem_req_addr  = (q.st == ST_RD0) ? l0_addr : l1_addr;
    assign done          = q.done;
    assign done_fault    = q.fault;
    assign done_cause    = q.cause;
    assign done_paddr    = q.pa;
    assign done_attr     = q.attr;
    assign done_mega     = q.mega;

    // R13
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    // R13
    req_in_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    // R13
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R2
    bare_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && !xlat_on) |=>
        (done && !done_fault && done_paddr == {2'b00, $past(req_vaddr)}));

    // R12
    cause_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault) |->
        (done_cause == CAUSE_FETCH || done_cause == CAUSE_LOAD || done_cause == CAUSE_STORE));

    // R12
    fault_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_fault) |-> (done_paddr == '0 && !done_mega));

    // R6
    mega_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_mega) |-> !done_fault);

endmodule

// File: tb/tb_xlat_walker.sv
`timescale 1ns/1ps
module tb_xlat_walker;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [1:0]  req_kind;
    logic        xlat_on;
    logic [21:0] root_ppn;
    logic        busy;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [33:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done;
    logic        done_fault;
    logic [3:0]  done_cause;
    logic [33:0] done_paddr;
    logic [9:0]  done_attr;
    logic        done_mega;

    always #2 clk = ~clk;

    xlat_walker dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_kind(req_kind),
        .xlat_on(xlat_on), .root_ppn(root_ppn), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done(done), .done_fault(done_fault),
        .done_cause(done_cause), .done_paddr(done_paddr),
        .done_attr(done_attr), .done_mega(done_mega)
    );

    typedef struct {
        logic        fault;
        logic [3:0]  cause;
        logic [33:0] pa;
        logic [9:0]  attr;
        logic        mega;
        int          nrd;
        logic [33:0] a1;
        logic [33:0] a0;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    logic [33:0] rd_log[$];
    logic [31:0] mem [logic [33:0]];
    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rdm(input logic [33:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    task automatic set_pte(input logic [21:0] tbl, input logic [9:0] idx, input logic [31:0] v);
        mem[{tbl, idx, 2'b00}] = v;
    endtask

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [31:0] va, input logic [1:0] kind,
                                   input logic on, input logic [21:0] root);
        exp_t e;
        logic [31:0] p;
        logic need;
        e.fault = 0; e.cause = 0; e.pa = 0; e.attr = 0; e.mega = 0;
        e.nrd = 0; e.a1 = 0; e.a0 = 0; e.tag = "";
        if (!on) begin
            e.pa = {2'b00, va};
            return e;
        end
        e.a1 = {root, va[31:22], 2'b00};
        e.nrd = 1;
        p = rdm(e.a1);
        if (p[0] && !(p[2] && !p[1]) && p[3:1] == 3'b000) begin
            e.a0 = {p[31:10], va[21:12], 2'b00};
            e.nrd = 2;
            p = rdm(e.a0);
            e.fault = !p[0] || (p[2] && !p[1]) || (p[3:1] == 3'b000);
            e.pa = {p[31:10], va[11:0]};
        end else begin
            e.fault = !p[0] || (p[2] && !p[1]) || (p[19:10] != 10'h0);
            e.pa = {p[31:20], va[21:0]};
            e.mega = 1;
        end
        need = (kind == 2'd1) ? p[2] : (kind == 2'd2) ? p[3] : p[1];
        if (!need) e.fault = 1;
        e.attr = p[9:0];
        if (e.fault) begin
            e.cause = (kind == 2'd1) ? 4'd15 : (kind == 2'd2) ? 4'd12 : 4'd13;
            e.pa = 0; e.attr = 0; e.mega = 0;
        end
        return e;
    endfunction

    // Memory responder with varying stalls
    int stall_sel = 0;
    int rdy_dly = 0;
    int lat = 0;
    bit pending = 0;
    logic [33:0] cap = '0;
    initial begin
        mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 0;
            if (mem_req_ready) begin
                mem_req_ready = 0;
                rd_log.push_back(cap);
                pending = 1;
                lat = stall_sel % 4;
                stall_sel++;
            end else if (pending) begin
                if (lat == 0) begin
                    mem_rsp_valid = 1;
                    mem_rsp_data  = rdm(cap);
                    pending = 0;
                    rdy_dly = stall_sel % 3;
                end else lat--;
            end else if (mem_req_valid) begin
                if (rdy_dly == 0) begin
                    mem_req_ready = 1;
                    cap = mem_req_addr;
                end else rdy_dly--;
            end
        end
    end

    // Monitor: pops the scoreboard on every completion
    always @(negedge clk) begin : mon
        exp_t e;
        if (rst_n && done) begin
            if (sb.size() == 0) begin
                chk(0, "R13", "completion with nothing pending", 1, 0);
            end else begin
                e = sb.pop_front();
                chk(done_fault == e.fault, e.tag, "fault", done_fault, e.fault);
                chk(done_cause == e.cause, e.tag, "cause", done_cause, e.cause);
                chk(done_paddr == e.pa, e.tag, "paddr", done_paddr, e.pa);
                chk(done_attr == e.attr, e.tag, "attr", done_attr, e.attr);
                chk(done_mega == e.mega, e.tag, "mega", done_mega, e.mega);
                chk(rd_log.size() == e.nrd, e.tag, "read count", rd_log.size(), e.nrd);
                if (rd_log.size() >= 1 && e.nrd >= 1)
                    chk(rd_log[0] == e.a1, e.tag, "first read addr", rd_log[0], e.a1);
                if (rd_log.size() >= 2 && e.nrd >= 2)
                    chk(rd_log[1] == e.a0, e.tag, "second read addr", rd_log[1], e.a0);
            end
            rd_log.delete();
        end
    end

    task automatic send(input logic [31:0] va, input logic [1:0] kind, input logic on,
                        input logic [21:0] root, input string tag);
        exp_t e;
        e = model(va, kind, on, root);
        e.tag = tag;
        while (busy) @(negedge clk);
        sb.push_back(e);
        req_vaddr = va; req_kind = kind; xlat_on = on; root_ppn = root;
        req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
        $finish;
    end

    localparam logic [21:0] ROOT  = 22'h00100;
    localparam logic [21:0] ROOT2 = 22'h3FF00;
    localparam logic [21:0] PT    = 22'h00200;

    initial begin
        rst_n = 0; req_valid = 0; req_vaddr = 0; req_kind = 0;
        xlat_on = 0; root_ppn = 0;

        set_pte(ROOT,  10'd1,  {PT, 10'h001});
        set_pte(ROOT2, 10'd1,  {PT, 10'h001});
        set_pte(PT,    10'd5,  {22'h3ABCDE, 2'b10, 8'hC7});
        set_pte(PT,    10'd6,  32'h0);
        set_pte(PT,    10'd7,  {22'h12345, 10'h001});
        set_pte(PT,    10'd8,  {22'h00777, 10'h005});
        set_pte(PT,    10'd9,  {22'h01111, 10'h009});
        set_pte(ROOT,  10'd16, {12'h2A5, 10'h000, 10'h00F});
        set_pte(ROOT,  10'd17, {12'h155, 10'h004, 10'h003});
        set_pte(ROOT,  10'd18, {12'h0AA, 10'h000, 10'h005});

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1
        chk(busy == 0, "R1", "busy after reset", busy, 0);
        chk(done == 0, "R1", "done after reset", done, 0);
        chk(mem_req_valid == 0, "R1", "mem_req_valid after reset", mem_req_valid, 0);

        send(32'hFEDC_BA98, 2'd0, 1'b0, ROOT, "R2");
        send({10'h001, 10'h005, 12'hABC}, 2'd0, 1'b1, ROOT,  "R3 R4 R5 load");
        send({10'h001, 10'h005, 12'h004}, 2'd1, 1'b1, ROOT,  "R5 store");
        send({10'h001, 10'h005, 12'h010}, 2'd1, 1'b1, ROOT2, "R3 other root");
        send({10'h001, 10'h005, 12'h020}, 2'd2, 1'b1, ROOT,  "R9 R12 fetch no X");
        send({10'h001, 10'h006, 12'h000}, 2'd1, 1'b1, ROOT,  "R7 R12 leaf invalid");
        send({10'h002, 10'h000, 12'h000}, 2'd0, 1'b1, ROOT,  "R7 dir invalid");
        send({10'h001, 10'h007, 12'h000}, 2'd0, 1'b1, ROOT,  "R8 nonleaf L0");
        send({10'h001, 10'h008, 12'h000}, 2'd1, 1'b1, ROOT,  "R10 W no R");
        send({10'h001, 10'h009, 12'h000}, 2'd0, 1'b1, ROOT,  "R9 load no R");
        send({10'h001, 10'h009, 12'h3FC}, 2'd2, 1'b1, ROOT,  "R9 fetch X");
        send({10'h001, 10'h009, 12'h000}, 2'd3, 1'b1, ROOT,  "R9 kind3 as load");
        send({10'h010, 10'h3C1, 12'h0F0}, 2'd2, 1'b1, ROOT,  "R6 mega fetch");
        send({10'h010, 10'h000, 12'hFFF}, 2'd0, 1'b1, ROOT,  "R6 mega load");
        send({10'h011, 10'h001, 12'h000}, 2'd0, 1'b1, ROOT,  "R11 misaligned");
        send({10'h012, 10'h001, 12'h000}, 2'd1, 1'b1, ROOT,  "R10 mega W no R");

        // R13: stray requests during a walk are ignored
        begin
            exp_t e;
            e = model({10'h001, 10'h005, 12'h111}, 2'd0, 1'b1, ROOT);
            e.tag = "R13 ignore";
            sb.push_back(e);
            req_vaddr = {10'h001, 10'h005, 12'h111}; req_kind = 0;
            xlat_on = 1; root_ppn = ROOT; req_valid = 1;
            @(negedge clk);
            chk(busy == 1, "R13", "busy after accept", busy, 1);
            req_vaddr = 32'h1234_5678; req_kind = 2'd1; xlat_on = 0;
            root_ppn = ROOT2;
            @(negedge clk);
            @(negedge clk);
            req_valid = 0;
            while (!done) @(negedge clk);
            @(negedge clk);
            chk(done == 0, "R13", "done width", done, 0);
            repeat (6) @(negedge clk);
            chk(busy == 0, "R13", "idle after walk", busy, 0);
        end

        chk(sb.size() == 0, "R13", "pending completions", sb.size(), 0);
        summary();
        $finish;
    end

endmodule